// File: doc/BRIEF.md
# Four-phase oversampling edge timestamper

This block time-stamps both transitions of one asynchronous digital hit line. Four sampling clocks share one frequency and sit a quarter period apart. Together they sample the line four times per period, so one time bin is a quarter of the sampling period. The absolute bin width is whatever the supplied clocks make it. Nothing in the logic depends on a particular frequency.

All four samples of one period are moved into the phase-0 domain as a four-bit window. A free-running coarse counter is captured with that window. Each edge yields one record holding a channel number, an edge-type bit, the coarse count and a two-bit fine code. The fine code names the phase that first saw the new level. Records enter a 16-entry ring that crosses into the readout clock domain. A reader drains the ring through a valid/ready port. `rec_valid` stays high and `rec_data` holds still until the reader raises `rec_ready`. One record leaves on each readout edge where both are high. When the ring is full, newer records are discarded and a sticky flag is raised.

Many channels use the same block and differ only in the channel-number parameter.

Top module: `tdc_channel`

## Requirements
- R1: Sampling instant j is at time t0 + j·(P/4). P is the sampling period. t0 is the phase-0 rising edge that follows the first phase-0 edge at which `rst` reads low. Phase k, with k = j mod 4, takes instant j. For an edge whose first sample at the new level is instant j, the timestamp in `rec_data[13:2]`,`rec_data[1:0]` equals j. The coarse part is j/4 and the fine part is j mod 4.
- R2: `rec_data[14]` is 1 for a low-to-high edge and 0 for a high-to-low edge. Consecutive records alternate in type, starting with a rising edge after reset.
- R3: Each window of four instants (4m to 4m+3) yields at most one record. A record is made only when the sample at 4m+3 differs from the level last recorded. Its fine code is the first instant in the window that differs from that level. A pulse that no sample sees, or that is back at the old level by instant 4m+3, makes no record.
- R4: The coarse field is the window index modulo 4096, and it wraps silently.
- R5: `rec_data[19:15]` carries the channel-number parameter.
- R6: Records leave in the order they were made. While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and `rec_data` is unchanged at the next readout edge.
- R7: The ring holds at most 16 records. A record made while the ring is full is dropped, and stored records are never overwritten. `overflow` goes high after a drop and stays high until reset.
- R8: While `rst` is high and just after it falls, `rec_valid` and `overflow` are 0 and the recorded level is low. The hit line must be low when reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_clk | input | 4 | Sampling clocks; bit k is delayed by k quarter periods from bit 0 |
| sys_clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous reset, active high, in the readout domain |
| hit | input | 1 | Asynchronous hit line |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | Reader accepts the record this cycle |
| rec_data | output | 20 | Record {channel, edge type, coarse, fine} |
| overflow | output | 1 | Sticky flag: at least one record was dropped |

## Verification
The hardest cases to reach are windows whose samples are not monotonic, and a full ring whose pointers must cross clock domains. The stimulus places each hit transition at a chosen fraction of a bin between two modelled phase edges. A pulse one bin wide can therefore land on an inner instant, where it must vanish, or on the last instant of a window, where it must produce a rising record and then a falling one. For the full-ring case, the reader is held off while twenty edges arrive. The first sixteen records must come out intact and the flag must latch.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_e;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end

endmodule

// File: rtl/tdc_phase_sampler.sv
module tdc_phase_sampler #(
  parameter int PHASES = 4
) (
  input  logic [PHASES-1:0] phase_clk,
  input  logic              hit,
  output logic [PHASES-1:0] window
);

  logic [PHASES-1:0] raw;

  // each phase takes the hit line on its own rising edge
  for (genvar k = 0; k < PHASES; k++) begin : g_phase
    logic smp;
    always_ff @(posedge phase_clk[k]) begin
      smp <= hit;
    end
    assign raw[k] = smp;
  end

  // one retiming stage on phase 0 gathers a whole period in time order
  always_ff @(posedge phase_clk[0]) begin
    window <= raw;
  end

endmodule

// File: rtl/tdc_edge_encoder.sv
module tdc_edge_encoder #(
  parameter int PHASES   = 4,
  parameter int COARSE_W = 12,
  parameter int CH_W     = 5,
  parameter int CH_ID    = 0,
  localparam int FINE_W  = $clog2(PHASES),
  localparam int REC_W   = CH_W + 1 + COARSE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] window,
  output logic              push,
  output logic [REC_W-1:0]  rec
);

  localparam int EDGE_BIT = COARSE_W + FINE_W;

  logic [COARSE_W-1:0] coarse_run;
  logic [COARSE_W-1:0] coarse_win;
  logic                level;
  logic [PHASES-1:0]   differ;
  logic                take;
  logic [FINE_W-1:0]   first;

  always_comb begin
    differ = window ^ {PHASES{level}};
    take   = differ[PHASES-1];
    first  = '0;
    for (int i = PHASES - 1; i >= 0; i--) begin
      if (differ[i]) first = FINE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_run <= '0;
      coarse_win <= '0;
      level      <= 1'b0;
      push       <= 1'b0;
      rec        <= '0;
    end else begin
      coarse_run <= coarse_run + 1'b1;
      coarse_win <= coarse_run;
      push       <= take;
      if (take) begin
        level <= window[PHASES-1];
        rec   <= {CH_W'(CH_ID), window[PHASES-1], coarse_win, first};
      end
    end
  end

  // checker state: type of the last record issued
  logic last_edge;
  always_ff @(posedge clk) begin
    if (rst) last_edge <= tdc_pkg::EDGE_FALL;
    else if (push) last_edge <= rec[EDGE_BIT];
  end

  AST_EDGE_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    push |-> (rec[EDGE_BIT] != last_edge)); // R2

endmodule

// File: rtl/tdc_ring_cdc.sv
module tdc_ring_cdc #(
  parameter int W      = 20,
  parameter int ADDR_W = 4
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rclk,
  input  logic         rrst,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         overflow
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nx;
  logic [PW-1:0] rbin, rgray, rbin_nx;
  logic [PW-1:0] rgray_w, wgray_r, rbin_w, occ_w;
  logic          full, wr_ok, ovf_w, ovf_r, pop;

  // ---------------- write side ----------------
  tdc_sync #(.W(PW)) u_rptr_sync (.clk(wclk), .d(rgray), .q(rgray_w));

  always_comb begin
    rbin_w  = PW'(tdc_pkg::gray_to_bin(32'(rgray_w)));
    occ_w   = wbin - rbin_w;
    full    = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    wr_ok   = wr_en && !full;
    wbin_nx = wbin + 1'b1;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      ovf_w <= 1'b0;
    end else begin
      if (wr_ok) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (wr_en && full) ovf_w <= 1'b1;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[ADDR_W-1:0]] <= wr_data;
  end

  AST_NO_OVERWRITE: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && full) |=> (wbin == $past(wbin))); // R7
  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (wrst)
    ovf_w |=> ovf_w); // R7
  AST_OCC_BOUND: assert property (@(posedge wclk) disable iff (wrst)
    occ_w <= PW'(DEPTH)); // R7

  // ---------------- read side ----------------
  tdc_sync #(.W(PW)) u_wptr_sync (.clk(rclk), .d(wgray), .q(wgray_r));
  tdc_sync #(.W(1))  u_ovf_sync  (.clk(rclk), .d(ovf_w), .q(ovf_r));

  always_comb begin
    rd_valid = (rgray != wgray_r);
    pop      = rd_valid && rd_ready;
    rd_data  = mem[rbin[ADDR_W-1:0]];
    rbin_nx  = rbin + 1'b1;
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rgray    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pop) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      overflow <= ovf_r;
    end
  end

  AST_HOLD_DATA: assert property (@(posedge rclk) disable iff (rrst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6
  AST_FLAG_STAYS: assert property (@(posedge rclk) disable iff (rrst)
    overflow |=> overflow); // R7

endmodule

// File: rtl/tdc_channel.sv
module tdc_channel #(
  parameter int PHASES   = 4,
  parameter int COARSE_W = 12,
  parameter int CH_W     = 5,
  parameter int CH_ID    = 0,
  parameter int ADDR_W   = 4,
  localparam int FINE_W  = $clog2(PHASES),
  localparam int REC_W   = CH_W + 1 + COARSE_W + FINE_W
) (
  input  logic [PHASES-1:0] phase_clk,
  input  logic              sys_clk,
  input  logic              rst,
  input  logic              hit,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [REC_W-1:0]  rec_data,
  output logic              overflow
);

  logic              rst_w;
  logic [PHASES-1:0] window;
  logic              push;
  logic [REC_W-1:0]  rec;

  tdc_sync #(.W(1)) u_rst_sync (
    .clk (phase_clk[0]),
    .d   (rst),
    .q   (rst_w)
  );

  tdc_phase_sampler #(.PHASES(PHASES)) u_sampler (
    .phase_clk (phase_clk),
    .hit       (hit),
    .window    (window)
  );

  tdc_edge_encoder #(
    .PHASES   (PHASES),
    .COARSE_W (COARSE_W),
    .CH_W     (CH_W),
    .CH_ID    (CH_ID)
  ) u_encoder (
    .clk    (phase_clk[0]),
    .rst    (rst_w),
    .window (window),
    .push   (push),
    .rec    (rec)
  );

  tdc_ring_cdc #(
    .W      (REC_W),
    .ADDR_W (ADDR_W)
  ) u_ring (
    .wclk     (phase_clk[0]),
    .wrst     (rst_w),
    .wr_en    (push),
    .wr_data  (rec),
    .rclk     (sys_clk),
    .rrst     (rst),
    .rd_valid (rec_valid),
    .rd_ready (rec_ready),
    .rd_data  (rec_data),
    .overflow (overflow)
  );

endmodule

// File: tb/tdc_channel_tb.sv
`timescale 1ns/1ps
module tdc_channel_tb;

  localparam int  CH    = 5;
  localparam int  DEPTH = 16;
  localparam real BIN   = 2.0;    // 8 ns phase period / 4
  localparam real TREF  = 116.0;  // second phase-0 edge after rst falls at 101

  logic p0, p1, p2, p3;
  logic [3:0] pclk;
  logic sys_clk, rst, hit, rec_ready;
  logic rec_valid, overflow;
  logic [19:0] rec_data;

  assign pclk = {p3, p2, p1, p0};

  tdc_channel #(.CH_ID(CH)) u_dut (
    .phase_clk (pclk),
    .sys_clk   (sys_clk),
    .rst       (rst),
    .hit       (hit),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_data  (rec_data),
    .overflow  (overflow)
  );

  initial begin p0 = 0; forever #4 p0 = ~p0; end
  initial begin p1 = 0; #2; forever #4 p1 = ~p1; end
  initial begin p2 = 0; #4; forever #4 p2 = ~p2; end
  initial begin p3 = 0; #6; forever #4 p3 = ~p3; end
  initial begin sys_clk = 0; forever #2.5 sys_clk = ~sys_clk; end

  int checks = 0;
  int errors = 0;
  int popped = 0;
  bit hold_off = 0;
  string cur_tag = "R8";

  typedef struct {
    logic [19:0] d;
    string       tag;
  } exp_t;
  exp_t expq[$];
  exp_t cmp_e;
  bit   exp_ovf = 0;

  // ---------------- behavioural reference ----------------
  bit [3:0] wbuf;
  bit       mlvl = 0;

  task automatic model_take(input int k);
    int j, m, f;
    exp_t e;
    if ($realtime > TREF - 0.5) begin
      j = int'(($realtime - TREF) / BIN);
      wbuf[k] = hit;
      if (k == 3 && wbuf[3] != mlvl) begin
        m = (j - 3) / 4;
        f = 3;
        for (int i = 3; i >= 0; i--) if (wbuf[i] != mlvl) f = i;
        e.d   = {5'(CH), wbuf[3], 12'(m % 4096), 2'(f)};
        e.tag = cur_tag;
        mlvl  = wbuf[3];
        if (expq.size() < DEPTH) expq.push_back(e);
        else exp_ovf = 1;
      end
    end
  endtask

  always @(posedge p0) model_take(0);
  always @(posedge p1) model_take(1);
  always @(posedge p2) model_take(2);
  always @(posedge p3) model_take(3);

  // compare every accepted record, away from the edge
  always @(negedge sys_clk) begin
    if (!rst && rec_valid && rec_ready) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected record act=%h exp=none", cur_tag, rec_data);
      end else begin
        cmp_e = expq.pop_front();
        if (rec_data !== cmp_e.d) begin
          errors++;
          $display("FAIL %s record act=%h exp=%h", cmp_e.tag, rec_data, cmp_e.d);
        end
        popped++;
      end
    end
  end

  // reader with a back-pressure pattern
  int rdy_cnt = 0;
  initial begin
    rec_ready = 0;
    forever begin
      @(posedge sys_clk);
      #1;
      rdy_cnt++;
      rec_ready = hold_off ? 1'b0 : ((rdy_cnt % 5) != 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic edge_at(input int j, input logic v, input real off);
    real dt;
    dt = TREF + BIN * j - off - $realtime;
    if (dt > 0.0) #(dt);
    hit = v;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (expq.size() != 0 && n < 3000) begin
      @(posedge sys_clk);
      n++;
    end
    repeat (20) @(posedge sys_clk);
    #2;
    chk(expq.size() == 0, tag, "pending expected", expq.size(), 0);
    chk(rec_valid == 1'b0, tag, "valid after drain", int'(rec_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge sys_clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    hit = 0;
    rst = 1;
    #101;
    rst = 0;
    #1;
    chk(rec_valid == 1'b0, "R8", "valid in reset", int'(rec_valid), 0);
    chk(overflow == 1'b0, "R8", "overflow in reset", int'(overflow), 0);

    // each fine code, both edge types, varied sub-bin offsets
    cur_tag = "R1/R2/R5";
    for (int k = 0; k < 8; k++) begin
      edge_at(20 + 17 * k, ((k % 2) == 0), 0.5 + 0.5 * (k % 3));
    end
    drain("R1");

    // pulse seen only on an inner instant: no record
    cur_tag = "R3";
    edge_at(201, 1'b1, 1.0);
    edge_at(201, 1'b0, -1.0);
    drain("R3");
    // pulse seen only on the last instant: rising then falling
    edge_at(215, 1'b1, 1.0);
    edge_at(215, 1'b0, -1.0);
    // bubble 0,1,0,1 inside one window: first transition taken
    edge_at(241, 1'b1, 1.0);
    edge_at(241, 1'b0, -1.0);
    edge_at(243, 1'b1, 1.0);
    edge_at(260, 1'b0, 0.5);
    drain("R3");

    // dense burst against back-pressure
    cur_tag = "R6";
    for (int k = 0; k < 6; k++) begin
      edge_at(300 + 8 * k, 1'b1, 0.7);
      edge_at(304 + 8 * k, 1'b0, 1.3);
    end
    drain("R6");

    // full ring: drop newest, latch flag
    cur_tag = "R7";
    chk(overflow == 1'b0, "R7", "overflow before fill", int'(overflow), 0);
    hold_off = 1;
    repeat (5) @(posedge sys_clk);
    for (int k = 0; k < 10; k++) begin
      edge_at(400 + 24 * k, 1'b1, 1.0);
      edge_at(412 + 24 * k, 1'b0, 1.0);
    end
    repeat (50) @(posedge sys_clk);
    #2;
    chk(overflow == 1'b1 && exp_ovf, "R7", "overflow after drop", int'(overflow), 1);
    chk(expq.size() == DEPTH, "R7", "kept records", expq.size(), DEPTH);
    chk(rec_valid == 1'b1, "R7", "valid while held", int'(rec_valid), 1);
    base = popped;
    hold_off = 0;
    drain("R7");
    chk(popped - base == DEPTH, "R7", "records drained", popped - base, DEPTH);
    chk(overflow == 1'b1, "R7", "overflow sticky", int'(overflow), 1);

    // coarse wrap at 4096 windows
    cur_tag = "R4";
    edge_at(16380, 1'b1, 1.0);
    edge_at(16386, 1'b0, 1.0);
    edge_at(16395, 1'b1, 0.5);
    edge_at(16401, 1'b0, 0.5);
    drain("R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule